// File: doc/BRIEF.md
# Multithreading Enable/Disable Controller

This block holds the threading control word of a core that is divided into several virtual processing elements. The word has one thread-enable bit per element and a single global enable bit. Four operations act on it. A local disable stops the other threads of the issuing element and leaves the other elements running. A local enable restores threading in the issuing element. A global disable leaves only the issuing thread running across the whole core. A global enable turns every element back on.

Every accepted disable returns the control word as it stood before the operation, so that software can save it. Software restores a saved word later through a direct write port, which overrides any operation arriving in the same cycle. This keeps nested critical regions correct.

The global operations are privileged. When the master-processor flag is low they raise a one-cycle exception and the control word does not change. The block also presents a per-element run permission, which the thread scheduler outside the block consumes.

Top module: `mt_enable_ctrl`

## Requirements
- R1: Reset (active-low, asynchronous) sets every bit of the control word to 1, and clears `rsp_valid`, `exc` and `old_word` to 0.
- R2: An operation with `op_valid`=1 and `op_code`=1 (local disable) clears only the element bit selected by `op_elem`. The change is visible after the clock edge. All other bits are unchanged, and the master flag has no effect on this operation.
- R3: An operation with `op_code`=2 (local enable) sets only the element bit selected by `op_elem`. All other bits are unchanged, and the master flag has no effect on this operation.
- R4: An operation with `op_code`=3 (global disable) and `op_master`=1 clears the global bit, which is bit NUM_ELEM of the word. The element bits, in positions NUM_ELEM-1 to 0, are unchanged.
- R5: An operation with `op_code`=4 (global enable) and `op_master`=1 sets the global bit. The element bits are unchanged.
- R6: In the cycle after an accepted disable (local, or global with master), `rsp_valid` is 1 for exactly one cycle and `old_word` carries the control word from before the operation. `old_word` holds its value until the next response. Enable operations do not raise `rsp_valid`.
- R7: A global operation (code 3 or 4) with `op_master`=0 raises `exc` for one cycle after the edge. It leaves the control word unchanged and produces no response.
- R8: `wr_en`=1 loads `wr_data` into the control word at the edge. Any operation presented in the same cycle is discarded: it causes no state change, no response and no exception.
- R9: With `op_valid`=0, or with a reserved code (0 or 5 to 7), the control word, `rsp_valid` and `exc` are unaffected.
- R10: `run_en[i]` equals the global bit AND element bit i of the current control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 1 local disable, 2 local enable, 3 global disable, 4 global enable |
| op_elem | input | IDW | Issuing element index |
| op_master | input | 1 | Master-processor privilege flag |
| wr_en | input | 1 | Direct write of the whole control word |
| wr_data | input | NUM_ELEM+1 | Word to load; bit NUM_ELEM is the global bit |
| thr_en | output | NUM_ELEM | Per-element thread-enable bits |
| glob_en | output | 1 | Global element-enable bit |
| run_en | output | NUM_ELEM | Effective run permission per element |
| rsp_valid | output | 1 | One-cycle pulse marking a returned old word |
| old_word | output | NUM_ELEM+1 | Control word from before the last accepted disable |
| exc | output | 1 | One-cycle privilege exception pulse |

## Verification
The clocked properties compare the control word with its value one edge earlier. They assume the inputs hold known, settled values at every rising edge after reset, and they are armed only once a full cycle has passed since reset. The bench therefore changes every input on the falling edge and keeps all inputs at zero while reset is applied. A local operation with an element index beyond NUM_ELEM-1 would leave the word unchanged, but the default of four elements cannot produce one, so the stimulus never reaches that case.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [2:0] {
    MTC_NOP     = 3'd0,
    MTC_DIS_LOC = 3'd1,
    MTC_EN_LOC  = 3'd2,
    MTC_DIS_ALL = 3'd3,
    MTC_EN_ALL  = 3'd4
  } mtc_op_e;

  function automatic logic is_global(input logic [2:0] code);
    return (code == MTC_DIS_ALL) || (code == MTC_EN_ALL);
  endfunction
endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_code,
  input  logic       op_master,
  input  logic       wr_en,
  output logic       clr_loc,
  output logic       set_loc,
  output logic       clr_glb,
  output logic       set_glb,
  output logic       want_rsp,
  output logic       fault
);
  logic live;
  logic allowed;

  // A direct write discards any operation in the same cycle.
  assign live    = op_valid && !wr_en;
  assign allowed = !is_global(op_code) || op_master;

  always_comb begin
    clr_loc = 1'b0;
    set_loc = 1'b0;
    clr_glb = 1'b0;
    set_glb = 1'b0;
    if (live && allowed) begin
      unique case (op_code)
        MTC_DIS_LOC: clr_loc = 1'b1;
        MTC_EN_LOC:  set_loc = 1'b1;
        MTC_DIS_ALL: clr_glb = 1'b1;
        MTC_EN_ALL:  set_glb = 1'b1;
        default: ;
      endcase
    end
  end

  assign want_rsp = clr_loc || clr_glb;
  assign fault    = live && is_global(op_code) && !op_master;

  AST_DEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_loc, set_loc, clr_glb, set_glb, fault})); // R9
endmodule

// File: rtl/mtc_state.sv
module mtc_state #(
  parameter int NUM_ELEM = 4,
  localparam int IDW = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int CW  = NUM_ELEM + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_loc,
  input  logic           set_loc,
  input  logic           clr_glb,
  input  logic           set_glb,
  input  logic [IDW-1:0] op_elem,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  ctrl_q
);
  logic [CW-1:0] ctrl_d;
  logic          chk_armed;

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_elem
    logic hit;
    assign hit = (op_elem == IDW'(gi));
    always_comb begin
      if (wr_en)                ctrl_d[gi] = wr_data[gi];
      else if (clr_loc && hit)  ctrl_d[gi] = 1'b0;
      else if (set_loc && hit)  ctrl_d[gi] = 1'b1;
      else                      ctrl_d[gi] = ctrl_q[gi];
    end
  end

  always_comb begin
    if (wr_en)        ctrl_d[NUM_ELEM] = wr_data[NUM_ELEM];
    else if (clr_glb) ctrl_d[NUM_ELEM] = 1'b0;
    else if (set_glb) ctrl_d[NUM_ELEM] = 1'b1;
    else              ctrl_d[NUM_ELEM] = ctrl_q[NUM_ELEM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '1;
    else        ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    $past(wr_en) |-> ctrl_q == $past(wr_data)); // R8
  AST_LOCAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    $past(clr_loc || set_loc) |->
      ($countones(ctrl_q ^ $past(ctrl_q)) <= 1) &&
      (ctrl_q[NUM_ELEM] == $past(ctrl_q[NUM_ELEM]))); // R2
  AST_GLB_KEEPS_ELEM: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    $past(clr_glb || set_glb) |->
      ctrl_q[NUM_ELEM-1:0] == $past(ctrl_q[NUM_ELEM-1:0])); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    $past(!wr_en && !clr_loc && !set_loc && !clr_glb && !set_glb) |-> $stable(ctrl_q)); // R9
endmodule

// File: rtl/mtc_resp.sv
module mtc_resp #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_rsp,
  input  logic          fault,
  input  logic [CW-1:0] ctrl_in,
  output logic          rsp_valid,
  output logic [CW-1:0] old_word,
  output logic          exc
);
  logic chk_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      exc       <= 1'b0;
      old_word  <= '0;
      chk_armed <= 1'b0;
    end else begin
      rsp_valid <= want_rsp;
      exc       <= fault;
      chk_armed <= 1'b1;
      if (want_rsp) old_word <= ctrl_in;
    end
  end

  AST_EXC_XOR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc && rsp_valid)); // R7
  AST_RSP_OLD: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    rsp_valid |-> old_word == $past(ctrl_in)); // R6
  AST_OLD_HELD: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    !rsp_valid |-> $stable(old_word)); // R6
endmodule

// File: rtl/mt_enable_ctrl.sv
module mt_enable_ctrl #(
  parameter int NUM_ELEM = 4,
  localparam int IDW = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int CW  = NUM_ELEM + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [IDW-1:0]      op_elem,
  input  logic                op_master,
  input  logic                wr_en,
  input  logic [CW-1:0]       wr_data,
  output logic [NUM_ELEM-1:0] thr_en,
  output logic                glob_en,
  output logic [NUM_ELEM-1:0] run_en,
  output logic                rsp_valid,
  output logic [CW-1:0]       old_word,
  output logic                exc
);
  logic          clr_loc, set_loc, clr_glb, set_glb, want_rsp, fault;
  logic [CW-1:0] ctrl_q;
  logic          chk_armed;

  mtc_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_master(op_master),
    .wr_en    (wr_en),
    .clr_loc  (clr_loc),
    .set_loc  (set_loc),
    .clr_glb  (clr_glb),
    .set_glb  (set_glb),
    .want_rsp (want_rsp),
    .fault    (fault)
  );

  mtc_state #(.NUM_ELEM(NUM_ELEM)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_loc (clr_loc),
    .set_loc (set_loc),
    .clr_glb (clr_glb),
    .set_glb (set_glb),
    .op_elem (op_elem),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  mtc_resp #(.CW(CW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_rsp (want_rsp),
    .fault    (fault),
    .ctrl_in  (ctrl_q),
    .rsp_valid(rsp_valid),
    .old_word (old_word),
    .exc      (exc)
  );

  assign thr_en  = ctrl_q[NUM_ELEM-1:0];
  assign glob_en = ctrl_q[NUM_ELEM];

  for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_run
    assign run_en[gi] = glob_en && thr_en[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  AST_EXC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
    exc |-> $stable({glob_en, thr_en})); // R7
  AST_RUN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> run_en == '0); // R10
endmodule

// File: tb/sim_mt_enable_ctrl.sv
module sim_mt_enable_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [1:0] op_elem = 2'd0;
  logic       op_master = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = 5'd0;
  logic [3:0] thr_en, run_en;
  logic       glob_en, rsp_valid, exc;
  logic [4:0] old_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mt_enable_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_elem(op_elem), .op_master(op_master), .wr_en(wr_en), .wr_data(wr_data),
    .thr_en(thr_en), .glob_en(glob_en), .run_en(run_en),
    .rsp_valid(rsp_valid), .old_word(old_word), .exc(exc)
  );

  // {wr, wdata[5], valid, code[3], elem[2], master, exp_ctrl[5], exp_rsp, exp_old[5], exp_exc}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    25'b0_00000_1_001_01_0_11101_1_11111_0,  // R2 local disable elem1
    25'b0_00000_1_001_01_0_11101_1_11101_0,  // R6 repeat returns current
    25'b0_00000_1_010_01_0_11111_0_11101_0,  // R3 local enable
    25'b0_00000_1_011_00_0_11111_0_11101_1,  // R7 global disable no master
    25'b0_00000_1_011_00_1_01111_1_11111_0,  // R4 global disable
    25'b0_00000_1_001_11_0_00111_1_01111_0,  // R2 elem3
    25'b0_00000_1_100_00_0_00111_0_01111_1,  // R7 global enable no master
    25'b0_00000_1_100_00_1_10111_0_01111_0,  // R5 global enable
    25'b0_00000_1_101_00_1_10111_0_01111_0,  // R9 reserved code
    25'b1_01010_1_011_00_1_01010_0_01111_0,  // R8 write wins
    25'b0_00000_1_010_00_1_01011_0_01111_0,  // R3 elem0
    25'b0_00000_0_001_00_0_01011_0_01111_0,  // R9 not valid
    25'b0_00000_1_001_00_0_01010_1_01011_0,  // R2 elem0
    25'b0_00000_1_100_00_1_11010_0_01011_0   // R5 global enable
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [4:0] ectl, input logic ersp,
                           input logic [4:0] eold, input logic eexc);
    logic [3:0] erun;
    erun = ectl[4] ? ectl[3:0] : 4'b0000;
    chk({req, " ctrl"}, {27'd0, glob_en, thr_en}, {27'd0, ectl});
    chk({req, " rsp"}, {31'd0, rsp_valid}, {31'd0, ersp});
    chk({req, " old"}, {27'd0, old_word}, {27'd0, eold});
    chk({req, " exc"}, {31'd0, exc}, {31'd0, eexc});
    chk("R10 run", {28'd0, run_en}, {28'd0, erun});
  endtask

  task automatic step(input logic w, input logic [4:0] wd, input logic v,
                      input logic [2:0] c, input logic [1:0] e, input logic m);
    wr_en = w; wr_data = wd; op_valid = v; op_code = c; op_elem = e; op_master = m;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset", 5'b11111, 1'b0, 5'b00000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      step(v[24], v[23:19], v[18], v[17:15], v[14:13], v[12]);
      check_all($sformatf("vector %0d", i), v[11:7], v[6], v[5:1], v[0]);
    end

    // R8: write beats a faulting global op: no exception
    step(1'b1, 5'b10101, 1'b1, 3'd4, 2'd0, 1'b0);
    check_all("R8 write over fault", 5'b10101, 1'b0, 5'b01011, 1'b0);

    // R6: response pulse lasts one cycle, old word then held
    step(1'b0, 5'b00000, 1'b1, 3'd1, 2'd2, 1'b0);
    check_all("R6 pulse", 5'b10001, 1'b1, 5'b10101, 1'b0);
    step(1'b0, 5'b00000, 1'b0, 3'd0, 2'd0, 1'b0);
    check_all("R6 pulse ends", 5'b10001, 1'b0, 5'b10101, 1'b0);

    // R7: exception pulse lasts one cycle
    step(1'b0, 5'b00000, 1'b1, 3'd3, 2'd0, 1'b0);
    check_all("R7 exc", 5'b10001, 1'b0, 5'b10101, 1'b1);
    step(1'b0, 5'b00000, 1'b0, 3'd0, 2'd0, 1'b0);
    check_all("R7 exc ends", 5'b10001, 1'b0, 5'b10101, 1'b0);

    // R1: reset mid-run restores all-ones
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid reset", 5'b11111, 1'b0, 5'b00000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule